// File: doc/BRIEF.md
# Gen3 SKP Ordered-Set Detector

This per-lane receive block sits behind the descrambler of a 128b/130b physical coding sublayer. Each clock it takes one 32-bit word, the 2-bit sync header of the current block and a block-start hint from the front end. It keeps its own count of word positions within 4-word blocks. It recognises SKP ordered sets, which run from a body of 0xAAAAAAAA words to an end word whose low byte is 0xE1. When a genuine SKP ordered set ends, the block adjusts its boundary so that the next word opens a new block.

Payload is scrambled, so a data block can by chance carry exactly the SKP body or SKP END pattern. The detector looks for a SKP only when an ordered-set header (2'b01) is present on the first word of a block. A data block that looks like SKP therefore never moves the block boundary. Results go out one cycle later on PIPE-style valid and status outputs, together with the word, a block-first marker and a SKP pulse.

The front end's block-start hint is used only to acquire alignment. After reset, or after the link controller signals recovery, the first hinted word becomes word 0 of a block. From then on the detector's own count decides where blocks begin. A malformed SKP makes the lane lose alignment. The lane then reports an error until recovery is signalled.

Top module: `skp_os_detector`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, `rx_valid`, `rx_status`, `skp_detected` and `blk_first` are all 0.
- R2: While hunting (after reset or after recovery), words without `blk_start` give `rx_valid`=0 with `rx_status`=3'b000. The first word with `blk_start` comes out with `rx_valid`=1 and `blk_first`=1.
- R3: Once aligned, blocks are 4 words long and `blk_first` marks word 0 of each block. `blk_start` has no effect on boundaries while aligned. Every output appears one clock after its input word, and `rx_data` equals that word.
- R4: A SKP is a block whose first word carries header 2'b01 and equals 0xAAAAAAAA. It has 1 to 5 body words of 0xAAAAAAAA, followed by a word whose bits [7:0] are 0xE1. On that end word `skp_detected` pulses for one cycle, and the next word is reported as word 0 of a new block.
- R5: A block with header 2'b10 never produces `skp_detected` or a boundary change, whatever its words are, including 0xAAAAAAAA and xxxxxxE1 patterns.
- R6: SKP patterns that do not start at the first word of a block are ignored, even inside a block with header 2'b01.
- R7: A block with header 2'b00 or 2'b11 reports `rx_status`=3'b100 on all four of its words. `rx_valid` stays 1 and the boundary is unchanged.
- R8: Inside a SKP, a word that is neither 0xAAAAAAAA nor has low byte 0xE1 causes loss of alignment, and so does a sixth body word. From that word on, `rx_valid`=0 and `rx_status`=3'b100 until recovery.
- R9: A `recover` pulse while alignment is lost returns the lane to hunting: `rx_valid`=0 and `rx_status`=3'b000 from that word on. `recover` has no effect while aligned.
- R10: In normal aligned operation `rx_status` is 3'b000, including on SKP words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 32 | Descrambled-side receive word |
| in_hdr | input | 2 | Sync header of the current block, sampled on its first word |
| blk_start | input | 1 | Front-end block-start hint, used only while hunting |
| recover | input | 1 | Recovery indication from the link controller |
| rx_data | output | 32 | Word delayed by one cycle |
| rx_valid | output | 1 | Lane aligned and word valid |
| rx_status | output | 3 | 3'b000 normal, 3'b100 decode or alignment error |
| skp_detected | output | 1 | One-cycle pulse on an accepted SKP end word |
| blk_first | output | 1 | Word is word 0 of a block |

## Verification
The hardest case to reach from the ports is a data block whose words match the SKP signature exactly, because scrambled traffic produces one only very rarely. The bench injects such blocks directly, with header 2'b10 and the body and end patterns, and also places the patterns mid-block under an ordered-set header. It then checks that `blk_first` still falls every four words. It also drives SKP sets with the minimum, a middle and the maximum body length, so that the boundary shift after a genuine SKP is seen next to the unchanged boundary after a fake one.

// File: rtl/skp_os_pkg.sv
package skp_os_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    LS_HUNT   = 2'd0,
    LS_LOCKED = 2'd1,
    LS_LOST   = 2'd2
  } lane_state_e;

  localparam logic [1:0]        HDR_OS        = 2'b01;
  localparam logic [1:0]        HDR_DATA      = 2'b10;
  localparam logic [WORD_W-1:0] SKP_BODY_WORD = 32'hAAAA_AAAA;
  localparam logic [7:0]        SKP_END_BYTE  = 8'hE1;
  localparam logic [2:0]        ST_OK         = 3'b000;
  localparam logic [2:0]        ST_DEC_ERR    = 3'b100;

  function automatic logic hdr_legal(input logic [1:0] h);
    return (h == HDR_OS) || (h == HDR_DATA);
  endfunction

  function automatic logic word_is_body(input logic [WORD_W-1:0] w);
    return w == SKP_BODY_WORD;
  endfunction

  function automatic logic word_is_end(input logic [WORD_W-1:0] w);
    return w[7:0] == SKP_END_BYTE;
  endfunction

endpackage

// File: rtl/skp_word_class.sv
module skp_word_class
  import skp_os_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        hdr,
  output logic              is_body,
  output logic              is_end,
  output logic              hdr_ok,
  output logic              hdr_os
);
  always_comb begin
    is_body = word_is_body(word);
    is_end  = word_is_end(word);
    hdr_ok  = hdr_legal(hdr);
    hdr_os  = (hdr == HDR_OS);
  end
endmodule

// File: rtl/skp_align_fsm.sv
module skp_align_fsm
  import skp_os_pkg::*;
#(
  parameter int BLK_WORDS = 4,
  parameter int MAX_BODY  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        blk_start,
  input  logic        recover,
  input  logic        is_body,
  input  logic        is_end,
  input  logic        hdr_ok,
  input  logic        hdr_os,
  output logic        o_valid,
  output logic [2:0]  o_status,
  output logic        o_skp,
  output logic        o_first,
  output lane_state_e mode,
  output logic        skp_active,
  output logic        ev_first,
  output logic        ev_lose
);
  localparam int POS_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
  localparam int CNT_W = $clog2(MAX_BODY + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK_WORDS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_BODY);

  lane_state_e      mode_n;
  logic [POS_W-1:0] wpos, wpos_n;
  logic [CNT_W-1:0] body_cnt, body_cnt_n;
  logic             skp_n, blk_bad, blk_bad_n;

  function automatic logic [POS_W-1:0] pos_step(input logic [POS_W-1:0] p);
    return (p == LAST_POS) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    mode_n     = mode;
    wpos_n     = wpos;
    body_cnt_n = body_cnt;
    skp_n      = skp_active;
    blk_bad_n  = blk_bad;
    o_valid    = 1'b0;
    o_status   = ST_OK;
    o_skp      = 1'b0;
    o_first    = 1'b0;
    ev_first   = 1'b0;
    ev_lose    = 1'b0;

    case (mode)
      LS_HUNT:   ev_first = blk_start;
      LS_LOCKED: ev_first = !skp_active && (wpos == '0);
      default:   ev_first = 1'b0;
    endcase

    if (mode == LS_LOST) begin
      if (recover) begin
        mode_n = LS_HUNT;
      end else begin
        o_status = ST_DEC_ERR;
      end
    end else if (ev_first) begin
      mode_n    = LS_LOCKED;
      o_valid   = 1'b1;
      o_first   = 1'b1;
      blk_bad_n = !hdr_ok;
      o_status  = hdr_ok ? ST_OK : ST_DEC_ERR;
      if (hdr_ok && hdr_os && is_body) begin
        skp_n      = 1'b1;
        body_cnt_n = CNT_W'(1);
        wpos_n     = '0;
      end else begin
        wpos_n = pos_step('0);
      end
    end else if (mode == LS_LOCKED && skp_active) begin
      if (is_body && body_cnt != CNT_MAX) begin
        body_cnt_n = body_cnt + 1'b1;
        o_valid    = 1'b1;
      end else if (!is_body && is_end) begin
        skp_n   = 1'b0;
        wpos_n  = '0;
        o_skp   = 1'b1;
        o_valid = 1'b1;
      end else begin
        ev_lose = 1'b1;
      end
    end else if (mode == LS_LOCKED) begin
      wpos_n   = pos_step(wpos);
      o_valid  = 1'b1;
      o_status = blk_bad ? ST_DEC_ERR : ST_OK;
    end

    if (ev_lose) begin
      mode_n   = LS_LOST;
      skp_n    = 1'b0;
      o_status = ST_DEC_ERR;
      o_valid  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= LS_HUNT;
      wpos       <= '0;
      body_cnt   <= '0;
      skp_active <= 1'b0;
      blk_bad    <= 1'b0;
    end else begin
      mode       <= mode_n;
      wpos       <= wpos_n;
      body_cnt   <= body_cnt_n;
      skp_active <= skp_n;
      blk_bad    <= blk_bad_n;
    end
  end
endmodule

// File: rtl/skp_out_stage.sv
module skp_out_stage
  import skp_os_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] d_word,
  input  logic              d_valid,
  input  logic [2:0]        d_status,
  input  logic              d_skp,
  input  logic              d_first,
  output logic [WORD_W-1:0] q_word,
  output logic              q_valid,
  output logic [2:0]        q_status,
  output logic              q_skp,
  output logic              q_first
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_word   <= '0;
      q_valid  <= 1'b0;
      q_status <= ST_OK;
      q_skp    <= 1'b0;
      q_first  <= 1'b0;
    end else begin
      q_word   <= d_word;
      q_valid  <= d_valid;
      q_status <= d_status;
      q_skp    <= d_skp;
      q_first  <= d_first;
    end
  end
endmodule

// File: rtl/skp_os_detector.sv
module skp_os_detector
  import skp_os_pkg::*;
#(
  parameter int BLK_WORDS = 4,
  parameter int MAX_BODY  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] in_word,
  input  logic [1:0]  in_hdr,
  input  logic        blk_start,
  input  logic        recover,
  output logic [31:0] rx_data,
  output logic        rx_valid,
  output logic [2:0]  rx_status,
  output logic        skp_detected,
  output logic        blk_first
);
  logic        cls_body, cls_end, cls_hdr_ok, cls_hdr_os;
  logic        nx_valid, nx_skp, nx_first;
  logic [2:0]  nx_status;
  lane_state_e mode;
  logic        skp_active, ev_first, ev_lose;

  skp_word_class u_class (
    .word    (in_word),
    .hdr     (in_hdr),
    .is_body (cls_body),
    .is_end  (cls_end),
    .hdr_ok  (cls_hdr_ok),
    .hdr_os  (cls_hdr_os)
  );

  skp_align_fsm #(
    .BLK_WORDS (BLK_WORDS),
    .MAX_BODY  (MAX_BODY)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .blk_start  (blk_start),
    .recover    (recover),
    .is_body    (cls_body),
    .is_end     (cls_end),
    .hdr_ok     (cls_hdr_ok),
    .hdr_os     (cls_hdr_os),
    .o_valid    (nx_valid),
    .o_status   (nx_status),
    .o_skp      (nx_skp),
    .o_first    (nx_first),
    .mode       (mode),
    .skp_active (skp_active),
    .ev_first   (ev_first),
    .ev_lose    (ev_lose)
  );

  skp_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .d_word   (in_word),
    .d_valid  (nx_valid),
    .d_status (nx_status),
    .d_skp    (nx_skp),
    .d_first  (nx_first),
    .q_word   (rx_data),
    .q_valid  (rx_valid),
    .q_status (rx_status),
    .q_skp    (skp_detected),
    .q_first  (blk_first)
  );
endmodule

// File: rtl/skp_os_detector_chk.sv
module skp_os_detector_chk
  import skp_os_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] in_hdr,
  input logic       blk_start,
  input logic       recover,
  input logic       rx_valid,
  input logic [2:0] rx_status,
  input logic       skp_detected,
  input logic       blk_first,
  input logic       skp_active,
  input logic       ev_first
);
  // R4: the SKP pulse never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    skp_detected |=> !skp_detected);

  // R4: the word after an accepted SKP end opens a block
  a_r4_realign_next: assert property (@(posedge clk) disable iff (rst)
    skp_detected |=> blk_first);

  // R3: a block start is only reported on a valid word
  a_r3_first_valid: assert property (@(posedge clk) disable iff (rst)
    blk_first |-> rx_valid);

  // R10: SKP end words carry normal status
  a_r10_skp_status_ok: assert property (@(posedge clk) disable iff (rst)
    skp_detected |-> (rx_valid && rx_status == ST_OK));

  // R8: lost alignment persists until recovery
  a_r8_lost_holds: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && rx_status == ST_DEC_ERR && !recover) |=>
      (!rx_valid && rx_status == ST_DEC_ERR));

  // R2: hunting without a start hint stays invalid
  a_r2_hunt_waits: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && rx_status == ST_OK && !blk_start) |=> !rx_valid);

  // R5: a data header on a block start never opens a SKP
  a_r5_data_no_skp: assert property (@(posedge clk) disable iff (rst)
    (ev_first && in_hdr == HDR_DATA) |=> !skp_active);

  // R7: an illegal header flags its first word but keeps the lane valid
  a_r7_illegal_hdr: assert property (@(posedge clk) disable iff (rst)
    (ev_first && !hdr_legal(in_hdr)) |=>
      (rx_valid && blk_first && rx_status == ST_DEC_ERR));
endmodule

bind skp_os_detector skp_os_detector_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_hdr       (in_hdr),
  .blk_start    (blk_start),
  .recover      (recover),
  .rx_valid     (rx_valid),
  .rx_status    (rx_status),
  .skp_detected (skp_detected),
  .blk_first    (blk_first),
  .skp_active   (skp_active),
  .ev_first     (ev_first)
);

// File: tb/tb_skp_os_detector.sv
module tb_skp_os_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_word = '0;
  logic [1:0]  in_hdr = 2'b10;
  logic        blk_start = 1'b0;
  logic        recover = 1'b0;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic [2:0]  rx_status;
  logic        skp_detected;
  logic        blk_first;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] BODY = 32'hAAAA_AAAA;
  localparam logic [2:0]  OK   = 3'b000;
  localparam logic [2:0]  ERR  = 3'b100;

  always #5 clk = ~clk;

  skp_os_detector dut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_hdr(in_hdr),
    .blk_start(blk_start), .recover(recover), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_status(rx_status),
    .skp_detected(skp_detected), .blk_first(blk_first)
  );

  task automatic check(input string req, input logic ev, input logic [2:0] es,
                       input logic ek, input logic ef, input logic [31:0] ew);
    checks++;
    if ({rx_valid, rx_status, skp_detected, blk_first, rx_data} !==
        {ev, es, ek, ef, ew}) begin
      errors++;
      $display("FAIL %s: got v=%b st=%b skp=%b first=%b data=%h, exp v=%b st=%b skp=%b first=%b data=%h",
               req, rx_valid, rx_status, skp_detected, blk_first, rx_data,
               ev, es, ek, ef, ew);
    end
  endtask

  // drive one word, then check the registered result one clock later
  task automatic push(input string req, input logic [31:0] w, input logic [1:0] h,
                      input logic bs, input logic rc, input logic ev,
                      input logic [2:0] es, input logic ek, input logic ef);
    @(negedge clk);
    in_word = w; in_hdr = h; blk_start = bs; recover = rc;
    @(posedge clk); #1;
    check(req, ev, es, ek, ef, w);
  endtask

  task automatic data_block(input string req, input logic [1:0] h, input logic [31:0] w0,
                            input logic [31:0] w1, input logic [31:0] w2,
                            input logic [31:0] w3, input logic [2:0] es);
    push(req, w0, h,     1'b0, 1'b0, 1'b1, es, 1'b0, 1'b1);
    push(req, w1, 2'b10, 1'b0, 1'b0, 1'b1, es, 1'b0, 1'b0);
    push(req, w2, 2'b10, 1'b0, 1'b0, 1'b1, es, 1'b0, 1'b0);
    push(req, w3, 2'b10, 1'b0, 1'b0, 1'b1, es, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1; check("R1 in reset", 1'b0, OK, 1'b0, 1'b0, 32'h0);
    @(negedge clk); rst = 1'b0;
    push("R1 first cycle", 32'h1111_0000, 2'b10, 1'b0, 1'b0, 1'b0, OK, 1'b0, 1'b0);
  endtask

  task automatic t_acquire();
    push("R2 hunt", 32'h2222_0001, 2'b10, 1'b0, 1'b0, 1'b0, OK, 1'b0, 1'b0);
    push("R2 lock", 32'h3333_0000, 2'b10, 1'b1, 1'b0, 1'b1, OK, 1'b0, 1'b1);
    push("R3 w1", 32'h3333_0001, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push("R3 w2 hint ignored", 32'h3333_0002, 2'b10, 1'b1, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push("R3 w3", 32'h3333_0003, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    data_block("R3 R10 next block", 2'b10, 32'h4, 32'h5, 32'h6, 32'h7, OK);
  endtask

  task automatic t_skp(input int nbody);
    push("R4 skp start", BODY, 2'b01, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b1);
    for (int i = 1; i < nbody; i++)
      push("R4 R10 skp body", BODY, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push("R4 skp end", 32'h5A3C_0FE1, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b1, 1'b0);
    data_block("R4 realigned block", 2'b10, 32'h8, 32'h9, 32'hA, 32'hB, OK);
  endtask

  task automatic t_false_data();
    data_block("R5 data = skp body", 2'b10, BODY, BODY, BODY, BODY, OK);
    data_block("R5 data = skp end", 2'b10, BODY, 32'h0000_00E1, 32'hC, 32'hD, OK);
    data_block("R5 boundary kept", 2'b10, 32'hE, 32'hF, 32'h10, 32'h11, OK);
  endtask

  task automatic t_midblock();
    data_block("R6 mid-block pattern", 2'b01, 32'h1E1E_1E1E, BODY, 32'hFFFF_FFE1, 32'h12, OK);
    data_block("R6 boundary kept", 2'b10, 32'h13, 32'h14, 32'h15, 32'h16, OK);
  endtask

  task automatic t_illegal();
    data_block("R7 hdr 00", 2'b00, BODY, BODY, 32'h17, 32'h18, ERR);
    data_block("R7 hdr 11", 2'b11, 32'h19, 32'h1A, 32'h1B, 32'h1C, ERR);
    data_block("R7 back to normal", 2'b10, 32'h1D, 32'h1E, 32'h1F, 32'h20, OK);
  endtask

  task automatic t_recover_locked();
    push("R9 recover ignored locked", 32'h21, 2'b10, 1'b0, 1'b1, 1'b1, OK, 1'b0, 1'b1);
    push("R9 still locked", 32'h22, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push("R9 still locked", 32'h23, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push("R9 still locked", 32'h24, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
  endtask

  task automatic relock(input string req);
    push(req, 32'h30, 2'b10, 1'b1, 1'b1, 1'b0, OK, 1'b0, 1'b0);
    push(req, 32'h31, 2'b10, 1'b0, 1'b0, 1'b0, OK, 1'b0, 1'b0);
    push(req, 32'h32, 2'b10, 1'b1, 1'b0, 1'b1, OK, 1'b0, 1'b1);
    push(req, 32'h33, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push(req, 32'h34, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push(req, 32'h35, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
  endtask

  task automatic t_bad_skp();
    push("R4 skp start", BODY, 2'b01, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b1);
    push("R8 bad byte", 32'hAAAA_AA55, 2'b10, 1'b0, 1'b0, 1'b0, ERR, 1'b0, 1'b0);
    push("R8 stays lost", 32'h25, 2'b10, 1'b1, 1'b0, 1'b0, ERR, 1'b0, 1'b0);
    push("R8 stays lost", BODY, 2'b01, 1'b0, 1'b0, 1'b0, ERR, 1'b0, 1'b0);
    relock("R9 recover relock");
  endtask

  task automatic t_long_skp();
    push("R4 skp start", BODY, 2'b01, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b1);
    for (int i = 1; i < 5; i++)
      push("R8 body within limit", BODY, 2'b10, 1'b0, 1'b0, 1'b1, OK, 1'b0, 1'b0);
    push("R8 sixth body word", BODY, 2'b10, 1'b0, 1'b0, 1'b0, ERR, 1'b0, 1'b0);
    push("R8 end too late", 32'h0000_00E1, 2'b10, 1'b0, 1'b0, 1'b0, ERR, 1'b0, 1'b0);
    relock("R9 recover after long skp");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_skp(1);
    t_skp(3);
    t_skp(5);
    t_false_data();
    t_midblock();
    t_illegal();
    t_recover_locked();
    t_bad_skp();
    t_long_skp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule